// File: doc/BRIEF.md
# Streaming Priority Bus Arbiter

This block decides which master owns the address path of a shared coherent bus. There is one processor-core requester and a parameterised number of I/O requesters. Each request line comes with a priority. I/O masters supply their own priority with each request. The core's priority comes from a configuration input that all core transactions share. A granted master may keep the bus for a run of consecutive transactions, called a stream. A grant held for one clock cycle counts as one address tenure.

A configuration input sets the maximum length of a stream. Another master can break into a running stream only if its priority is strictly higher than the priority of the master that holds the bus. When a stream ends, the bus goes to the highest-priority requester. Ties among I/O masters are resolved round-robin. The core streams only while its streaming-enable input is set.

Top module: `stream_bus_arbiter`

## Requirements
- R1: `gnt` is zero or one-hot. Bit 0 is the core and bit k+1 is I/O master k. A grant is registered: it appears one cycle after the edge at which it was decided, and only for a master whose request was high at that edge.
- R2: During reset, and in the cycle after an edge with no request high, `gnt` and `strm_active` are both 0.
- R3: The maximum stream length is `strm_len_cfg` + 1 consecutive tenures. A value of 0 gives single tenures with no streaming, and 3 allows four tenures.
- R4: `strm_active` is 1 in every cycle whose grant continues the stream of the previous cycle's owner (tenures 2..n). It is 0 in the first tenure of a stream.
- R5: A request whose priority is equal to or lower than the owner's priority does not interrupt a stream.
- R6: A request with strictly higher priority pre-empts the stream at the next edge. The pre-empting master starts a fresh stream at count 1. The interrupted master must re-arbitrate, and it starts a fresh count if it wins again.
- R7: When the owner drops its request, the stream ends and the bus goes to the highest-priority requester at that edge.
- R8: Among I/O masters of equal top priority, the grant rotates round-robin, starting after the I/O master granted last. After reset, I/O master 0 is first in that order.
- R9: The core's priority is `core_prio`. At equal priority the I/O masters win over the core, so a core priority of 0 never interrupts, nor wins against, a requesting I/O master.
- R10: The core streams only while `core_strm_en` is 1. Otherwise each core tenure is arbitrated on its own, and `strm_active` stays 0 while the core holds the bus.
- R11: When a stream reaches its limit, the owner takes part in the new arbitration. If the owner is still the winner, it gets a new stream starting at count 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Core request |
| core_prio | input | PRIO_W | Priority of all core transactions |
| core_strm_en | input | 1 | Allows the core to stream |
| io_req | input | N_IO | I/O master requests |
| io_prio | input | N_IO*PRIO_W | I/O priorities; master k occupies bits k*PRIO_W upward |
| strm_len_cfg | input | 2 | Stream length minus one |
| gnt | output | N_IO+1 | One-hot grant: bit 0 is the core, bit k+1 is I/O master k |
| strm_active | output | 1 | Current grant continues a stream |

## Verification
The bench checks stream lengths at all four settings of the length field. An off-by-one in the limit would stretch or clip each run, and the `strm_active` pattern would show it. It raises equal-priority and strictly-higher-priority competitors in the middle of a stream. A design that used a non-strict comparison would either break streams on ties or refuse a genuine pre-emption. After a pre-emption, the bench lets the interrupted master win again and expects `strm_active` low, which catches a design that resumes the old count. It also covers round-robin order across three tied masters, the core at priority 0 against an I/O stream, and the core with streaming turned off. A wrong tie rule would starve the wrong master, and a design that ignores the enable would keep the core in a stream.

// File: rtl/sba_pkg.sv
package sba_pkg;
    localparam int CNT_W = 3;
    localparam int CFG_W = 2;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [CFG_W-1:0] cfg_t;
endpackage

// File: rtl/sba_prio_max.sv
module sba_prio_max #(
    parameter int NM     = 4,
    parameter int PRIO_W = 3
) (
    input  logic [NM-1:0]        req,
    input  logic [NM*PRIO_W-1:0] prio,
    output logic [PRIO_W-1:0]    max_prio,
    output logic [NM-1:0]        cand
);
    always_comb begin
        max_prio = '0;
        for (int m = 0; m < NM; m++) begin
            if (req[m] && (prio[m*PRIO_W +: PRIO_W] > max_prio))
                max_prio = prio[m*PRIO_W +: PRIO_W];
        end
        for (int m = 0; m < NM; m++) begin
            cand[m] = req[m] && (prio[m*PRIO_W +: PRIO_W] == max_prio);
        end
    end
endmodule

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
    parameter int N     = 3,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     cand,
    input  logic [IDX_W-1:0] last,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(last) + k) % N;
            if (!found && cand[j]) begin
                found = 1'b1;
                idx   = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/stream_bus_arbiter.sv
module stream_bus_arbiter
    import sba_pkg::*;
#(
    parameter int N_IO   = 3,
    parameter int PRIO_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   core_req,
    input  logic [PRIO_W-1:0]      core_prio,
    input  logic                   core_strm_en,
    input  logic [N_IO-1:0]        io_req,
    input  logic [N_IO*PRIO_W-1:0] io_prio,
    input  logic [CFG_W-1:0]       strm_len_cfg,
    output logic [N_IO:0]          gnt,
    output logic                   strm_active
);
    localparam int NM     = N_IO + 1;
    localparam int MIDX_W = (NM > 1) ? $clog2(NM) : 1;
    localparam int RR_W   = (N_IO > 1) ? $clog2(N_IO) : 1;

    typedef struct packed {
        logic              valid;
        logic [MIDX_W-1:0] owner;
        cnt_t              cnt;
        logic [RR_W-1:0]   rr_last;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NM-1:0]        req_all;
    logic [NM*PRIO_W-1:0] prio_all;
    logic [PRIO_W-1:0]    max_prio;
    logic [NM-1:0]        cand_all;
    logic                 io_found;
    logic [RR_W-1:0]      io_idx;
    logic [PRIO_W-1:0]    owner_prio;
    logic                 owner_req;
    logic                 strm_allowed;
    cnt_t                 limit;
    logic                 keep;

    assign req_all  = {io_req, core_req};
    assign prio_all = {io_prio, core_prio};

    sba_prio_max #(.NM(NM), .PRIO_W(PRIO_W)) u_max (
        .req      (req_all),
        .prio     (prio_all),
        .max_prio (max_prio),
        .cand     (cand_all)
    );

    sba_rr_pick #(.N(N_IO), .IDX_W(RR_W)) u_rr (
        .cand  (cand_all[NM-1:1]),
        .last  (st_q.rr_last),
        .found (io_found),
        .idx   (io_idx)
    );

    always_comb begin
        owner_prio   = prio_all[st_q.owner*PRIO_W +: PRIO_W];
        owner_req    = req_all[st_q.owner];
        strm_allowed = (st_q.owner != '0) || core_strm_en;
        limit        = cnt_t'(strm_len_cfg) + cnt_t'(1);
        keep         = st_q.valid && owner_req && strm_allowed
                       && (st_q.cnt < limit) && !(max_prio > owner_prio);

        st_d = st_q;
        if (keep) begin
            st_d.cnt = st_q.cnt + cnt_t'(1);
        end else if (io_found) begin
            st_d.valid   = 1'b1;
            st_d.owner   = MIDX_W'(io_idx) + MIDX_W'(1);
            st_d.cnt     = cnt_t'(1);
            st_d.rr_last = io_idx;
        end else if (cand_all[0]) begin
            st_d.valid = 1'b1;
            st_d.owner = '0;
            st_d.cnt   = cnt_t'(1);
        end else begin
            st_d.valid = 1'b0;
            st_d.owner = '0;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid   <= 1'b0;
            st_q.owner   <= '0;
            st_q.cnt     <= '0;
            st_q.rr_last <= RR_W'(N_IO - 1);
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar m = 0; m < NM; m++) begin : g_gnt
        assign gnt[m] = st_q.valid && (st_q.owner == MIDX_W'(m));
    end

    assign strm_active = st_q.valid && (st_q.cnt > cnt_t'(1));
endmodule

// File: rtl/sba_checker.sv
module sba_checker
    import sba_pkg::*;
#(
    parameter int N_IO   = 3,
    parameter int PRIO_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   core_req,
    input logic [PRIO_W-1:0]      core_prio,
    input logic                   core_strm_en,
    input logic [N_IO-1:0]        io_req,
    input logic [CFG_W-1:0]       strm_len_cfg,
    input logic [N_IO:0]          gnt,
    input logic                   strm_active
);
    cnt_t run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            run_q <= '0;
        else if (gnt == '0)    run_q <= '0;
        else if (strm_active)  run_q <= run_q + cnt_t'(1);
        else                   run_q <= cnt_t'(1);
    end

    AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R1

    AST_GNT_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~$past({io_req, core_req})) == '0); // R1

    AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past({io_req, core_req}) == '0) |-> (gnt == '0 && !strm_active)); // R2

    AST_STREAM_SAME_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        strm_active |-> (gnt != '0 && gnt == $past(gnt))); // R4

    AST_STREAM_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        strm_active |-> (run_q <= cnt_t'($past(strm_len_cfg)))); // R3

    AST_CORE_ZERO_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(core_prio == '0 && (gnt[N_IO:1] & io_req) != '0) |-> !gnt[0]); // R9

    AST_CORE_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!core_strm_en) |-> !(strm_active && gnt[0])); // R10
endmodule

bind stream_bus_arbiter sba_checker #(.N_IO(N_IO), .PRIO_W(PRIO_W)) u_sba_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_req     (core_req),
    .core_prio    (core_prio),
    .core_strm_en (core_strm_en),
    .io_req       (io_req),
    .strm_len_cfg (strm_len_cfg),
    .gnt          (gnt),
    .strm_active  (strm_active)
);

// File: tb/tb_stream_bus_arbiter.sv
module tb_stream_bus_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N_IO   = 3;
    localparam int PRIO_W = 3;

    localparam logic [3:0] G_NONE = 4'b0000;
    localparam logic [3:0] G_CORE = 4'b0001;
    localparam logic [3:0] G_IO0  = 4'b0010;
    localparam logic [3:0] G_IO1  = 4'b0100;
    localparam logic [3:0] G_IO2  = 4'b1000;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   core_req = 1'b0;
    logic [PRIO_W-1:0]      core_prio = '0;
    logic                   core_strm_en = 1'b1;
    logic [N_IO-1:0]        io_req = '0;
    logic [N_IO*PRIO_W-1:0] io_prio = '0;
    logic [1:0]             strm_len_cfg = 2'd3;
    logic [N_IO:0]          gnt;
    logic                   strm_active;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [N_IO:0] g;
        logic          sa;
        string         tag;
    } exp_t;

    exp_t exp_q[$];

    stream_bus_arbiter #(.N_IO(N_IO), .PRIO_W(PRIO_W)) dut (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_prio(core_prio),
        .core_strm_en(core_strm_en), .io_req(io_req), .io_prio(io_prio),
        .strm_len_cfg(strm_len_cfg), .gnt(gnt), .strm_active(strm_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    // Driver: the result of the coming edge is queued, then one cycle passes.
    task automatic step(input logic [N_IO:0] g, input logic sa, input string tag);
        exp_t e;
        e.g = g; e.sa = sa; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic set_io(input int k, input logic r, input int p);
        io_req[k] = r;
        io_prio[k*PRIO_W +: PRIO_W] = PRIO_W'(p);
    endtask

    task automatic clear_all();
        io_req   = '0;
        core_req = 1'b0;
    endtask

    // Monitor: compares each edge's outcome with the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (gnt !== e.g || strm_active !== e.sa) begin
                    n_fails++;
                    $display("FAIL %s: gnt=%b strm_active=%b expected gnt=%b strm_active=%b",
                             e.tag, gnt, strm_active, e.g, e.sa);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (gnt !== G_NONE || strm_active !== 1'b0) begin
            n_fails++;
            $display("FAIL R2 reset: gnt=%b sa=%b expected gnt=%b sa=0", gnt, strm_active, G_NONE);
        end
        rst_n = 1'b1;
        step(G_NONE, 1'b0, "R2 idle after reset");

        // Four-tenure stream and renewed stream at the limit
        set_io(0, 1'b1, 1);
        step(G_IO0, 1'b0, "R3 first tenure");
        step(G_IO0, 1'b1, "R4 second tenure");
        step(G_IO0, 1'b1, "R4 third tenure");
        step(G_IO0, 1'b1, "R3 fourth tenure");
        step(G_IO0, 1'b0, "R11 new stream at limit");
        step(G_IO0, 1'b1, "R11 new stream continues");
        clear_all();
        step(G_NONE, 1'b0, "R2 no request");

        // Length setting 1: runs of two
        strm_len_cfg = 2'd1;
        set_io(2, 1'b1, 1);
        step(G_IO2, 1'b0, "R3 cfg1 t1");
        step(G_IO2, 1'b1, "R3 cfg1 t2");
        step(G_IO2, 1'b0, "R3 cfg1 restart");
        step(G_IO2, 1'b1, "R3 cfg1 t2 again");
        clear_all();
        step(G_NONE, 1'b0, "R2 no request");

        // Length setting 2: runs of three
        strm_len_cfg = 2'd2;
        set_io(2, 1'b1, 1);
        step(G_IO2, 1'b0, "R3 cfg2 t1");
        step(G_IO2, 1'b1, "R3 cfg2 t2");
        step(G_IO2, 1'b1, "R3 cfg2 t3");
        step(G_IO2, 1'b0, "R3 cfg2 restart");
        clear_all();
        step(G_NONE, 1'b0, "R2 no request");

        // Length setting 0 with three tied masters: round-robin, last was io2
        strm_len_cfg = 2'd0;
        set_io(0, 1'b1, 2); set_io(1, 1'b1, 2); set_io(2, 1'b1, 2);
        step(G_IO0, 1'b0, "R8 rr io0");
        step(G_IO1, 1'b0, "R8 rr io1");
        step(G_IO2, 1'b0, "R8 rr io2");
        step(G_IO0, 1'b0, "R3 cfg0 rr wraps");
        clear_all();
        step(G_NONE, 1'b0, "R2 no request");

        // Equal priority does not break a stream
        strm_len_cfg = 2'd3;
        set_io(2, 1'b1, 3);
        step(G_IO2, 1'b0, "R5 owner starts");
        set_io(0, 1'b1, 3);
        step(G_IO2, 1'b1, "R5 tie held");
        step(G_IO2, 1'b1, "R5 tie held");
        step(G_IO2, 1'b1, "R5 tie held");
        step(G_IO0, 1'b0, "R8 tie handover after limit");
        step(G_IO0, 1'b1, "R5 new owner streams");
        clear_all();
        step(G_NONE, 1'b0, "R2 no request");

        // Strictly higher pre-empts; interrupted master restarts its count
        set_io(1, 1'b1, 2);
        step(G_IO1, 1'b0, "R6 owner t1");
        step(G_IO1, 1'b1, "R6 owner t2");
        set_io(2, 1'b1, 5);
        step(G_IO2, 1'b0, "R6 pre-empt");
        step(G_IO2, 1'b1, "R6 pre-emptor streams");
        set_io(2, 1'b0, 5);
        step(G_IO1, 1'b0, "R7 drop hands over, R6 fresh count");
        step(G_IO1, 1'b1, "R6 fresh count t2");
        clear_all();
        step(G_NONE, 1'b0, "R2 no request");

        // Core at priority 0 cannot interrupt nor win a tie
        core_prio = 3'd0;
        core_strm_en = 1'b1;
        set_io(0, 1'b1, 0);
        step(G_IO0, 1'b0, "R9 io stream start");
        core_req = 1'b1;
        step(G_IO0, 1'b1, "R9 core0 waits");
        step(G_IO0, 1'b1, "R9 core0 waits");
        step(G_IO0, 1'b1, "R9 core0 waits");
        step(G_IO0, 1'b0, "R9 io wins tie vs core");
        set_io(0, 1'b0, 0);
        step(G_CORE, 1'b0, "R7 core after io drops");
        step(G_CORE, 1'b1, "R10 core streams when enabled");
        clear_all();
        step(G_NONE, 1'b0, "R2 no request");

        // High core priority pre-empts an I/O stream
        set_io(1, 1'b1, 3);
        step(G_IO1, 1'b0, "R9 io1 start");
        core_prio = 3'd6;
        core_req = 1'b1;
        step(G_CORE, 1'b0, "R9 core pre-empts");
        step(G_CORE, 1'b1, "R9 core streams");
        clear_all();
        step(G_NONE, 1'b0, "R2 no request");

        // Core streaming disabled
        core_prio = 3'd2;
        core_strm_en = 1'b0;
        core_req = 1'b1;
        step(G_CORE, 1'b0, "R10 core single");
        step(G_CORE, 1'b0, "R10 core no stream");
        set_io(0, 1'b1, 2);
        step(G_IO0, 1'b0, "R10 core re-arbitrates, io wins tie");
        step(G_IO0, 1'b1, "R5 io0 holds vs equal core");
        clear_all();
        step(G_NONE, 1'b0, "R2 no request");

        // Core streaming enabled: tie does not break the core stream
        core_strm_en = 1'b1;
        core_req = 1'b1;
        step(G_CORE, 1'b0, "R10 core start");
        set_io(0, 1'b1, 2);
        step(G_CORE, 1'b1, "R10 core stream kept");
        step(G_CORE, 1'b1, "R5 core stream kept");
        step(G_CORE, 1'b1, "R3 core fourth tenure");
        step(G_IO0, 1'b0, "R9 io wins after core limit");
        clear_all();
        step(G_NONE, 1'b0, "R2 no request");

        @(posedge clk);
        #2;
        finish_run();
    end
endmodule